// File: doc/BRIEF.md
# Multi-Precision Integer Sequencer

This block runs scalar integer operations of two widths through one W-bit add path and one W-by-W multiplier. Narrow operations (add, subtract, multiply, multiply with addend, population count, bit-field insert and bit-field extract) work on the low W bits of the operands. Wide operations (add, subtract, multiply, multiply with addend on 2W bits) are split into a sequence of narrow micro-steps. The carry moves from the low half to the high half, and partial products build up in an accumulator.

A request is taken when `in_valid` and `in_ready` are both high at a rising edge. The first micro-step runs on that same edge. Each later step takes one more edge, and `in_ready` stays low until the last step has been taken. An operation of N steps therefore occupies N cycles. The result appears on `out_res` with a one-cycle `out_done` pulse in the cycle after its last step, and `in_ready` is high again in that same cycle.

Opcode `in_op[3:0]` selects the operation: 0 add, 1 subtract, 2 multiply, 3 multiply-add, 4 population count, 5 field insert, 6 field extract, 8 wide add, 9 wide subtract, 10 wide multiply, 11 wide multiply-add. `in_op[4]` is the signed flag.

Top module: `int_seq_alu`

## Requirements
- R1: Add, subtract, population count, field insert, field extract and unused codes take one cycle. `out_done` is high in the cycle after acceptance, `in_ready` stays high, and back-to-back requests finish in consecutive cycles in order.
- R2: Codes 0 and 1 return `in_a[W-1:0]` plus or minus `in_b[W-1:0]` modulo 2^W. Bits above W-1 of every narrow result are zero.
- R3: Codes 2 and 3 take two cycles and return the low W bits of a*b, or of a*b+c, over the full W-bit operands. `in_ready` is low in the second cycle.
- R4: Codes 8 and 9 take two cycles and return a+b or a-b modulo 2^(2W). The carry or borrow of the low half feeds the high half.
- R5: Codes 10 and 11 take four cycles and return the low 2W bits of a*b, or of a*b+c.
- R6: Code 4 returns the number of set bits in `in_a[W-1:0]`.
- R7: Code 5 replaces bits pos..pos+len-1 of `in_b[W-1:0]` with the low bits of `in_a`. Bits that would fall at or above W are dropped. A len of 0 returns `in_b[W-1:0]` unchanged.
- R8: Code 6 with `in_op[4]`=0 returns bits pos..pos+len-1 of `in_a[W-1:0]`, zero-extended, with the field cut off at bit W-1. A len of 0 returns 0.
- R9: With `in_op[4]`=1, code 6 sign-extends the extracted field from its top kept bit. Every other code gives the same result for either value of `in_op[4]`.
- R10: `out_done` pulses exactly once per accepted operation and is never high while a sequence is in progress. A request presented while `in_ready` is low is neither taken nor affects the running result.
- R11: Codes 7 and 12 to 15 return zero after one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_op | input | 5 | Bit 4 signed flag, bits 3:0 operation code |
| in_a | input | 2W | First operand |
| in_b | input | 2W | Second operand; base word for field insert |
| in_c | input | 2W | Addend for multiply-add |
| in_pos | input | log2(W) | Field start bit |
| in_len | input | log2(W) | Field length in bits |
| out_res | output | 2W | Result, held until the next completion |
| out_done | output | 1 | One-cycle completion strobe |

## Verification
The completion of a multi-cycle sequence and the arrival of the next request can fall in the same cycle. `in_ready` rises together with `out_done`, and a request already waiting is then taken on the following edge. The bench provokes this in two ways. It holds `in_valid` high with an unrelated opcode throughout a wide multiply, and it streams single-cycle requests with no gap. It then judges the outcome by three observations: the wide result must match the product of the first request, exactly one strobe must appear per accepted operation, and the back-to-back results must appear in order on consecutive cycles.

// File: rtl/int_seq_pkg.sv
`timescale 1ns/1ps
package int_seq_pkg;
   localparam int OP_W = 5;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_MUL  = 4'd2,
      OP_MAC  = 4'd3,
      OP_POPC = 4'd4,
      OP_BINS = 4'd5,
      OP_BEXT = 4'd6,
      OP_ADDW = 4'd8,
      OP_SUBW = 4'd9,
      OP_MULW = 4'd10,
      OP_MACW = 4'd11
   } op_e;

   // number of micro-steps an operation code occupies
   function automatic logic [2:0] op_steps(input logic [3:0] code);
      case (code)
         OP_MUL, OP_MAC, OP_ADDW, OP_SUBW: op_steps = 3'd2;
         OP_MULW, OP_MACW:                 op_steps = 3'd4;
         default:                          op_steps = 3'd1;
      endcase
   endfunction
endpackage

// File: rtl/int_seq_addsub.sv
`timescale 1ns/1ps
module int_seq_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         sub,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W-1:0] y_eff;
   logic [W:0]   total;

   assign y_eff = sub ? ~y : y;
   assign total = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, cin};
   assign sum   = total[W-1:0];
   assign cout  = total[W];
endmodule

// File: rtl/int_seq_mul.sv
`timescale 1ns/1ps
module int_seq_mul #(
   parameter int W = 32,
   parameter bit SPLIT = 1'b0
) (
   input  logic [W-1:0]   x,
   input  logic [W-1:0]   y,
   output logic [2*W-1:0] p
);
   localparam int H = W / 2;

   generate
      if (SPLIT) begin : g_split
         // four half-width products summed, shallower multiplier cells
         logic [W-1:0]   ll, lh, hl, hh;
         assign ll = {{H{1'b0}}, x[H-1:0]} * {{H{1'b0}}, y[H-1:0]};
         assign lh = {{H{1'b0}}, x[H-1:0]} * {{H{1'b0}}, y[W-1:H]};
         assign hl = {{H{1'b0}}, x[W-1:H]} * {{H{1'b0}}, y[H-1:0]};
         assign hh = {{H{1'b0}}, x[W-1:H]} * {{H{1'b0}}, y[W-1:H]};
         assign p  = {{W{1'b0}}, ll} + ({{W{1'b0}}, lh} << H)
                   + ({{W{1'b0}}, hl} << H) + {hh, {W{1'b0}}};
      end else begin : g_flat
         assign p = {{W{1'b0}}, x} * {{W{1'b0}}, y};
      end
   endgenerate
endmodule

// File: rtl/int_seq_bitops.sv
`timescale 1ns/1ps
module int_seq_bitops #(
   parameter int W  = 32,
   parameter int PW = $clog2(W)
) (
   input  logic [W-1:0]  a,
   input  logic [W-1:0]  b,
   input  logic [PW-1:0] pos,
   input  logic [PW-1:0] len,
   input  logic          sgn,
   output logic [W-1:0]  popc,
   output logic [W-1:0]  ins,
   output logic [W-1:0]  ext
);
   localparam logic [PW:0] W_V = (PW+1)'(W);

   logic [PW:0]  end_pos, eff, sidx;
   logic [W-1:0] a_sh, a_rs;
   logic         sbit;
   logic [PW:0]  cnt;

   assign end_pos = {1'b0, pos} + {1'b0, len};
   assign eff     = (end_pos > W_V) ? (W_V - {1'b0, pos}) : {1'b0, len};
   assign sidx    = eff - (PW+1)'(1);
   assign a_sh    = a << pos;
   assign a_rs    = a >> pos;
   assign sbit    = sgn && (eff != '0) && a_rs[sidx[PW-1:0]];

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         localparam logic [PW:0] IDX = (PW+1)'(i);
         logic in_field;
         assign in_field = (IDX >= {1'b0, pos}) && (IDX < end_pos);
         assign ins[i]   = in_field ? a_sh[i] : b[i];
         assign ext[i]   = (IDX < eff) ? a_rs[i] : sbit;
      end
   endgenerate

   always_comb begin
      cnt = '0;
      for (int k = 0; k < W; k++) cnt = cnt + (PW+1)'(a[k]);
   end
   assign popc = W'(cnt);

   // R8: a zero length never yields a nonzero unsigned field
   always_comb begin
      if (len == '0 && !sgn) a_r8_empty_field: assert (ext == '0);
   end
endmodule

// File: rtl/int_seq_alu.sv
`timescale 1ns/1ps
module int_seq_alu
   import int_seq_pkg::*;
#(
   parameter int W = 32,
   parameter bit MUL_SPLIT = 1'b0,
   localparam int PW = $clog2(W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [OP_W-1:0]    in_op,
   input  logic [2*W-1:0]     in_a,
   input  logic [2*W-1:0]     in_b,
   input  logic [2*W-1:0]     in_c,
   input  logic [PW-1:0]      in_pos,
   input  logic [PW-1:0]      in_len,
   output logic [2*W-1:0]     out_res,
   output logic               out_done
);
   localparam int DW = 2 * W;

   generate
      if (W < 8 || (1 << PW) != W) begin : g_bad_width
         $error("int_seq_alu: W must be a power of two of at least 8");
      end
   endgenerate

   logic           busy_q, carry_q, done_q;
   logic [1:0]     step_q;
   logic [3:0]     op_q;
   logic [DW-1:0]  a_q, b_q, c_q, acc_q, res_q;

   logic [3:0]     cur_op;
   logic [DW-1:0]  ca, cb, cc;
   logic [1:0]     step;
   logic           fire, last, is_sub;
   logic [2:0]     nsteps;

   assign in_ready = !busy_q;
   assign fire     = busy_q || in_valid;
   assign cur_op   = busy_q ? op_q : in_op[3:0];
   assign ca       = busy_q ? a_q : in_a;
   assign cb       = busy_q ? b_q : in_b;
   assign cc       = busy_q ? c_q : in_c;
   assign step     = busy_q ? step_q : 2'd0;
   assign nsteps   = op_steps(cur_op);
   assign last     = ({1'b0, step} + 3'd1) == nsteps;
   assign is_sub   = (cur_op == OP_SUB) || (cur_op == OP_SUBW);

   // narrow add path: low half on step 0, high half with carry on step 1
   logic [W-1:0] ax, ay, asum;
   logic         acin, acout;
   assign ax   = (step == 2'd1) ? ca[DW-1:W] : ca[W-1:0];
   assign ay   = (step == 2'd1) ? cb[DW-1:W] : cb[W-1:0];
   assign acin = (step == 2'd1) ? carry_q : is_sub;

   int_seq_addsub #(.W(W)) u_add (
      .x(ax), .y(ay), .sub(is_sub), .cin(acin), .sum(asum), .cout(acout)
   );

   // multiplier operand select: lo*lo, lo*hi, hi*lo
   logic [W-1:0]  mx, my;
   logic [DW-1:0] pp;
   assign mx = (step == 2'd2) ? ca[DW-1:W] : ca[W-1:0];
   assign my = (step == 2'd1) ? cb[DW-1:W] : cb[W-1:0];

   int_seq_mul #(.W(W), .SPLIT(MUL_SPLIT)) u_mul (.x(mx), .y(my), .p(pp));

   logic [W-1:0] popc_v, ins_v, ext_v;
   int_seq_bitops #(.W(W), .PW(PW)) u_bits (
      .a(in_a[W-1:0]), .b(in_b[W-1:0]), .pos(in_pos), .len(in_len),
      .sgn(in_op[4]), .popc(popc_v), .ins(ins_v), .ext(ext_v)
   );

   // accumulator adder shared by partial-product build-up and addend fold
   logic [DW-1:0] acc_in, acc_sum;
   always_comb begin
      acc_in = '0;
      case (cur_op)
         OP_MAC:  acc_in = {{W{1'b0}}, cc[W-1:0]};
         OP_MULW: if (step != 2'd3) acc_in = {pp[W-1:0], {W{1'b0}}};
         OP_MACW: acc_in = (step == 2'd3) ? cc : {pp[W-1:0], {W{1'b0}}};
         default: acc_in = '0;
      endcase
   end
   assign acc_sum = acc_q + acc_in;

   logic [DW-1:0] acc_d, res_d;
   logic          carry_d;
   always_comb begin
      acc_d   = acc_q;
      carry_d = carry_q;
      res_d   = '0;
      case (cur_op)
         OP_ADD, OP_SUB: res_d = {{W{1'b0}}, asum};
         OP_MUL, OP_MAC: begin
            if (step == 2'd0) acc_d = pp;
            res_d = {{W{1'b0}}, acc_sum[W-1:0]};
         end
         OP_POPC: res_d = {{W{1'b0}}, popc_v};
         OP_BINS: res_d = {{W{1'b0}}, ins_v};
         OP_BEXT: res_d = {{W{1'b0}}, ext_v};
         OP_ADDW, OP_SUBW: begin
            if (step == 2'd0) begin
               acc_d   = {{W{1'b0}}, asum};
               carry_d = acout;
            end
            res_d = {asum, acc_q[W-1:0]};
         end
         OP_MULW, OP_MACW: begin
            acc_d = (step == 2'd0) ? pp : acc_sum;
            res_d = acc_sum;
         end
         default: res_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         step_q  <= 2'd0;
         carry_q <= 1'b0;
         op_q    <= '0;
         a_q     <= '0;
         b_q     <= '0;
         c_q     <= '0;
         acc_q   <= '0;
         res_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (fire) begin
            acc_q   <= acc_d;
            carry_q <= carry_d;
            if (!busy_q) begin
               op_q <= in_op[3:0];
               a_q  <= in_a;
               b_q  <= in_b;
               c_q  <= in_c;
            end
            if (last) begin
               res_q  <= res_d;
               done_q <= 1'b1;
               busy_q <= 1'b0;
               step_q <= 2'd0;
            end else begin
               busy_q <= 1'b1;
               step_q <= step + 2'd1;
            end
         end
      end
   end

   assign out_res  = res_q;
   assign out_done = done_q;

   logic take;
   assign take = in_valid && in_ready;

   a_r1_single_done: assert property (@(posedge clk) disable iff (!rst_n)
      (take && op_steps(in_op[3:0]) == 3'd1) |=> (out_done && in_ready));

   a_r3_mul_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (in_op[3:0] == OP_MUL || in_op[3:0] == OP_MAC))
      |=> !in_ready ##1 out_done);

   a_r4_wide_add_seq: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (in_op[3:0] == OP_ADDW || in_op[3:0] == OP_SUBW))
      |=> !out_done ##1 out_done);

   a_r5_wide_mul_seq: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (in_op[3:0] == OP_MULW || in_op[3:0] == OP_MACW))
      |=> !in_ready ##1 !in_ready ##1 !in_ready ##1 out_done);

   a_r10_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !out_done);

   a_r7_ins_keep_base: assert property (@(posedge clk) disable iff (!rst_n)
      (take && in_op[3:0] == OP_BINS && in_len == '0)
      |=> out_res == {{W{1'b0}}, $past(in_b[W-1:0])});
endmodule

// File: tb/int_seq_alu_bench.sv
`timescale 1ns/1ps
module int_seq_alu_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [4:0]  in_op = '0;
   logic [63:0] in_a = '0, in_b = '0, in_c = '0;
   logic [4:0]  in_pos = '0, in_len = '0;
   logic [63:0] out_res;
   logic        out_done;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   int_seq_alu #(.W(32)) u_int_seq_alu (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_c(in_c),
      .in_pos(in_pos), .in_len(in_len), .out_res(out_res), .out_done(out_done)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int steps_of(input logic [3:0] c);
      case (c)
         4'd2, 4'd3, 4'd8, 4'd9: return 2;
         4'd10, 4'd11:           return 4;
         default:                return 1;
      endcase
   endfunction

   function automatic logic [63:0] bext_ref(input logic [31:0] a, input int pos, input int len, input bit sgn);
      logic [31:0] r = '0;
      int eff = (pos + len > 32) ? 32 - pos : len;
      for (int k = 0; k < eff; k++) r[k] = a[pos+k];
      if (sgn && eff > 0 && r[eff-1])
         for (int k = eff; k < 32; k++) r[k] = 1'b1;
      return {32'b0, r};
   endfunction

   function automatic logic [63:0] bins_ref(input logic [31:0] a, input logic [31:0] b, input int pos, input int len);
      logic [31:0] r = b;
      for (int k = 0; k < len; k++) if (pos + k < 32) r[pos+k] = a[k];
      return {32'b0, r};
   endfunction

   function automatic logic [63:0] arith_ref(input logic [3:0] c, input logic [63:0] a, input logic [63:0] b, input logic [63:0] d);
      logic [31:0] t;
      case (c)
         4'd0: begin t = a[31:0] + b[31:0]; return {32'b0, t}; end
         4'd1: begin t = a[31:0] - b[31:0]; return {32'b0, t}; end
         4'd2: begin t = a[31:0] * b[31:0]; return {32'b0, t}; end
         4'd3: begin t = a[31:0] * b[31:0] + d[31:0]; return {32'b0, t}; end
         4'd4: return 64'($countones(a[31:0]));
         4'd8: return a + b;
         4'd9: return a - b;
         4'd10: return a * b;
         4'd11: return a * b + d;
         default: return 64'd0;
      endcase
   endfunction

   // one request: timing and result judged together; poke keeps valid high while busy
   task automatic run(input logic [4:0] op, input logic [63:0] a, input logic [63:0] b,
                      input logic [63:0] c, input int pos, input int len,
                      input logic [63:0] exp, input string tag, input bit poke);
      int n = steps_of(op[3:0]);
      bit ok = 1'b1;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_op = op; in_a = a; in_b = b; in_c = c;
      in_pos = 5'(pos); in_len = 5'(len);
      in_valid = 1'b1;
      for (int i = 1; i <= n + 1; i++) begin
         @(negedge clk);
         if (i == 1) begin
            in_valid = poke && (n > 1);
            if (poke) begin
               in_op = 5'd0; in_a = 64'h5555; in_b = 64'h7777; in_c = 64'h1;
            end
         end
         if (i == n) in_valid = 1'b0;
         if (i < n && out_done) ok = 1'b0;
         if (i == n && !(out_done && out_res == exp)) ok = 1'b0;
         if (i == n + 1 && out_done) ok = 1'b0;
      end
      chk(ok, tag, out_res, exp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [63:0] pats [8];
      pats[0] = 64'h0;
      pats[1] = 64'h1;
      pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
      pats[3] = 64'h8000_0000_0000_0000;
      pats[4] = 64'h0000_0000_FFFF_FFFF;
      pats[5] = 64'h0000_0001_0000_0000;
      pats[6] = 64'h1234_5678_9ABC_DEF0;
      pats[7] = 64'hDEAD_BEEF_CAFE_F00D;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state: idle, no strobe, cleared result (R1, R10)
      chk(in_ready && !out_done && out_res == 64'd0, "R1 reset state", out_res, 64'd0);

      // arithmetic sweep over corner patterns; signed flag toggled (R2-R6, R9)
      begin
         logic [3:0] codes [9];
         codes[0] = 4'd0; codes[1] = 4'd1; codes[2] = 4'd2; codes[3] = 4'd3;
         codes[4] = 4'd4; codes[5] = 4'd8; codes[6] = 4'd9; codes[7] = 4'd10;
         codes[8] = 4'd11;
         for (int k = 0; k < 9; k++) begin
            for (int i = 0; i < 8; i++) begin
               for (int j = 0; j < 8; j++) begin
                  logic [63:0] d = pats[(i + j + 3) % 8];
                  bit s = (i + j) % 2;
                  string tag;
                  case (codes[k])
                     4'd0, 4'd1:   tag = "R2 narrow add/sub";
                     4'd2, 4'd3:   tag = "R3 narrow multiply";
                     4'd4:         tag = "R6 population count";
                     4'd8, 4'd9:   tag = "R4 wide add/sub";
                     default:      tag = "R5 wide multiply";
                  endcase
                  if (s) tag = {tag, " R9 signed flag"};
                  run({s, codes[k]}, pats[i], pats[j], d, 0, 0,
                      arith_ref(codes[k], pats[i], pats[j], d), tag, 1'b0);
               end
            end
         end
      end

      // full position/length sweep of the field unit (R7, R8, R9)
      for (int p = 0; p < 32; p++) begin
         for (int l = 0; l < 32; l++) begin
            logic [31:0] av = 32'hA5C3_96F1 ^ (32'(p * 37 + l) * 32'h0101_0101);
            logic [31:0] bv = 32'h3C5A_F00F ^ (32'(l) << 7);
            run({1'b0, 4'd5}, {32'hFFFF_0000, av}, {32'h0F0F_0F0F, bv}, 64'd0, p, l,
                bins_ref(av, bv, p, l), "R7 field insert", 1'b0);
            run({1'b0, 4'd6}, {32'hFFFF_0000, av}, 64'd0, 64'd0, p, l,
                bext_ref(av, p, l, 1'b0), "R8 field extract", 1'b0);
            run({1'b1, 4'd6}, {32'h0, ~av}, 64'd0, 64'd0, p, l,
                bext_ref(~av, p, l, 1'b1), "R9 signed extract", 1'b0);
            run({1'b1, 4'd5}, {32'h0, bv}, {32'h0, av}, 64'd0, p, l,
                bins_ref(bv, av, p, l), "R9 insert ignores flag", 1'b0);
         end
      end

      // unused codes (R11)
      run(5'd7,  pats[7], pats[6], pats[2], 3, 4, 64'd0, "R11 unused code 7", 1'b0);
      for (int c = 12; c < 16; c++)
         run(5'(c), pats[2], pats[7], pats[6], 1, 1, 64'd0, "R11 unused code", 1'b0);

      // request held while busy must not disturb the running op (R10)
      run(5'd11, pats[7], pats[6], pats[5], 0, 0, pats[7] * pats[6] + pats[5],
          "R10 wide mul-add with request pending", 1'b1);
      run(5'd3, pats[6], pats[7], pats[2], 0, 0, arith_ref(4'd3, pats[6], pats[7], pats[2]),
          "R10 narrow mul-add with request pending", 1'b1);
      run(5'd9, pats[5], pats[1], 64'd0, 0, 0, pats[5] - pats[1],
          "R10 wide borrow with request pending", 1'b1);

      // back-to-back single-cycle requests (R1)
      @(negedge clk);
      in_op = 5'd0; in_a = 64'd7; in_b = 64'd9; in_valid = 1'b1;
      @(negedge clk);
      in_op = 5'd4; in_a = 64'hF0F0; in_valid = 1'b1;
      chk(out_done && out_res == 64'd16, "R1 first of stream", out_res, 64'd16);
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_done && out_res == 64'd8, "R1 second of stream", out_res, 64'd8);
      @(negedge clk);
      chk(!out_done && in_ready, "R1 stream ends", {63'd0, out_done}, 64'd0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule